// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of an event timer. It watches a free-running 64-bit main counter that is supplied from outside. It holds a comparator value, a period value and four configuration bits. When the counter has reached or passed the comparator, the channel emits a one-cycle match strobe.

In periodic mode, each match moves the comparator forward by the period. When the counter has run far ahead, the channel catches up one period per clock. A narrow mode restricts the comparison and all stored values to 32 bits. In narrow one-shot mode, the channel also emits a rollover strobe when the low 32 bits of the counter wrap before the match has happened.

Software writes the channel in 32-bit halves through a simple write port. A self-clearing set-value bit chooses whether a periodic channel's comparator write goes to the comparator or to the period.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period reads 0, the configuration reads 0, and both strobes are low.
- R2: The configuration field is written with `wr_sel`=0 and read on `cfg_o`. Bit 0 is channel enable, bit 1 is periodic, bit 2 is narrow (32-bit) mode and bit 3 is set-value. A configuration write with bit 2 set clears the upper 32 bits of both the stored comparator and the stored period in the same cycle.
- R3: In narrow mode the match decision uses only the low 32 bits of the counter and the comparator, and the decision wraps at 32 bits. In narrow mode a write to the upper half (`wr_sel`=2) has no effect.
- R4: A write to the lower half (`wr_sel`=1) or the upper half (`wr_sel`=2) loads the comparator when periodic is 0 or set-value is 1. Otherwise the write loads the same half of the period.
- R5: A value written into the period has its top bit cleared. In narrow mode that is bit 31 of a lower-half write. In wide mode that is bit 63, taken from a upper-half write.
- R6: Set-value reads 0 after any write that is accepted into the comparator or the period.
- R7: The channel matches when counter minus comparator is non-negative as a signed number, so a comparator already behind the counter matches at once. `match_o` is high for exactly the one cycle after the clock edge at which the counter was sampled. Without an intervening write, a one-shot channel strobes only once. A comparator of all ones in wide mode never matches.
- R8: In periodic mode with a nonzero period, every clock at which the counter has passed the comparator adds the period to the comparator, one addition per clock. In narrow mode the sum wraps at 32 bits. A catch-up sequence gives a single strobe.
- R9: In narrow one-shot mode, `wrap_o` pulses when the counter's low 32 bits step from all ones to zero before the match has occurred. It never pulses in periodic or wide mode, or after the match.
- R10: While `cnt_run` is low or the enable bit is 0, no strobe is raised and the comparator does not advance. A comparator that was passed while the channel was halted matches at the first running clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_run | input | 1 | Main counter is running |
| cnt_val | input | 64 | Main counter value |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | 0 configuration, 1 lower half, 2 upper half, 3 no target |
| wr_data | input | 32 | Write data |
| match_o | output | 1 | Match strobe |
| wrap_o | output | 1 | Narrow one-shot rollover strobe |
| cmp_o | output | 64 | Stored comparator |
| period_o | output | 64 | Stored period |
| cfg_o | output | 4 | Configuration bits |

## Verification
The counter is swept one step at a time through windows around the comparator in each mode. The sweeps cover:
- a wide one-shot sweep, which shows the exact match cycle and that the match does not repeat;
- a periodic sweep, which separates correct reload spacing from a missed or doubled strobe;
- a narrow sweep whose upper counter bits are nonzero and which crosses the 32-bit rollover, which shows that the high bits are ignored and that the comparator sum wraps;
- a held counter far ahead of the comparator, which counts the catch-up cycles and strobes.

Two narrow one-shot sweeps across the rollover place the comparator after and before the wrap point, which tells the rollover strobe apart from a late match. Halted sweeps, and writes whose routing depends on the periodic and set-value bits, show where each value lands and that the top bit is cleared.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;

  typedef struct packed {
    logic setval;
    logic narrow;
    logic periodic;
    logic enable;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    SEL_CFG    = 2'd0,
    SEL_CMP_LO = 2'd1,
    SEL_CMP_HI = 2'd2,
    SEL_NONE   = 2'd3
  } wr_target_e;

endpackage

// File: rtl/evt_cmp_regs.sv
module evt_cmp_regs
  import evt_cmp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  adv_i,
  input  logic [2*WORD_W-1:0]   adv_val_i,
  output chan_cfg_t             cfg_q,
  output logic [2*WORD_W-1:0]   cmp_q,
  output logic [2*WORD_W-1:0]   per_q,
  output logic                  wr_touch_o
);
  localparam int CNT_W = 2 * WORD_W;

  // clear the top bit of a word headed for the period
  function automatic logic [WORD_W-1:0] f_clip(input logic [WORD_W-1:0] d);
    return {1'b0, d[WORD_W-2:0]};
  endfunction

  logic wr_cfg, wr_lo, wr_hi, to_cmp;

  assign wr_cfg     = wr_en && (wr_sel == SEL_CFG);
  assign wr_lo      = wr_en && (wr_sel == SEL_CMP_LO);
  assign wr_hi      = wr_en && (wr_sel == SEL_CMP_HI) && !cfg_q.narrow;
  assign to_cmp     = !cfg_q.periodic || cfg_q.setval;
  assign wr_touch_o = wr_cfg || wr_lo || wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmp_q <= '1;
      per_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= chan_cfg_t'(wr_data[3:0]);
      if (wr_data[2]) begin
        cmp_q[CNT_W-1:WORD_W] <= '0;
        per_q[CNT_W-1:WORD_W] <= '0;
      end
    end else if (wr_lo || wr_hi) begin
      if (to_cmp) begin
        if (wr_lo) cmp_q[WORD_W-1:0]     <= wr_data;
        else       cmp_q[CNT_W-1:WORD_W] <= wr_data;
      end else begin
        if (wr_lo) per_q[WORD_W-1:0]     <= cfg_q.narrow ? f_clip(wr_data) : wr_data;
        else       per_q[CNT_W-1:WORD_W] <= f_clip(wr_data);
      end
      cfg_q.setval <= 1'b0;
    end else if (adv_i) begin
      cmp_q <= adv_val_i;
    end
  end

  assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.narrow |-> (cmp_q[CNT_W-1:WORD_W] == '0) && (per_q[CNT_W-1:WORD_W] == '0));

  assert_period_msb_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !per_q[CNT_W-1]);

  assert_setval_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |=> !cfg_q.setval);

endmodule

// File: rtl/evt_cmp_detect.sv
module evt_cmp_detect #(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic                  en_i,
  input  logic                  periodic_i,
  input  logic                  narrow_i,
  input  logic                  wr_touch_i,
  input  logic [2*WORD_W-1:0]   cnt_i,
  input  logic [2*WORD_W-1:0]   cmp_i,
  input  logic [2*WORD_W-1:0]   per_i,
  output logic                  adv_o,
  output logic [2*WORD_W-1:0]   adv_val_o,
  output logic                  match_o,
  output logic                  wrap_o
);
  localparam int CNT_W = 2 * WORD_W;

  // counter has reached or passed the comparator (sign of the difference)
  function automatic logic f_passed(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] k,
                                    input logic nar);
    logic [CNT_W-1:0] d;
    d = c - k;
    return nar ? !d[WORD_W-1] : !d[CNT_W-1];
  endfunction

  // next comparator after one period, wrapped to the active width
  function automatic logic [CNT_W-1:0] f_advance(input logic [CNT_W-1:0] k,
                                                 input logic [CNT_W-1:0] p,
                                                 input logic nar);
    logic [WORD_W-1:0] lo;
    lo = k[WORD_W-1:0] + p[WORD_W-1:0];
    return nar ? {{WORD_W{1'b0}}, lo} : k + p;
  endfunction

  logic active, passed_now, fire, wrap_hit, armed, prev_ones, lo_zero;

  assign active     = run_i && en_i;
  assign passed_now = f_passed(cnt_i, cmp_i, narrow_i) && !(cmp_i == '1);
  assign fire       = active && passed_now && armed && !wr_touch_i;
  assign adv_o      = active && periodic_i && (per_i != '0) && passed_now && !wr_touch_i;
  assign adv_val_o  = f_advance(cmp_i, per_i, narrow_i);
  assign lo_zero    = (cnt_i[WORD_W-1:0] == '0);
  assign wrap_hit   = active && !periodic_i && narrow_i && armed && !passed_now
                      && prev_ones && lo_zero && !wr_touch_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b1;
      prev_ones <= 1'b0;
      match_o   <= 1'b0;
      wrap_o    <= 1'b0;
    end else begin
      prev_ones <= (cnt_i[WORD_W-1:0] == '1);
      match_o   <= fire;
      wrap_o    <= wrap_hit;
      if (wr_touch_i)      armed <= 1'b1;
      else if (adv_o)      armed <= !f_passed(cnt_i, adv_val_o, narrow_i);
      else if (passed_now) armed <= armed && !fire;
      else                 armed <= 1'b1;
    end
  end

  assert_one_shot_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !adv_o) |=> !fire);

  assert_halted_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !match_o && !wrap_o);

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_run,
  input  logic [2*WORD_W-1:0]   cnt_val,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [WORD_W-1:0]     wr_data,
  output logic                  match_o,
  output logic                  wrap_o,
  output logic [2*WORD_W-1:0]   cmp_o,
  output logic [2*WORD_W-1:0]   period_o,
  output logic [3:0]            cfg_o
);
  localparam int CNT_W = 2 * WORD_W;

  chan_cfg_t        cfg_q;
  logic [CNT_W-1:0] cmp_q, per_q, adv_val;
  logic             adv, wr_touch;

  evt_cmp_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .adv_i(adv), .adv_val_i(adv_val), .cfg_q(cfg_q), .cmp_q(cmp_q), .per_q(per_q),
    .wr_touch_o(wr_touch)
  );

  evt_cmp_detect #(.WORD_W(WORD_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .run_i(cnt_run), .en_i(cfg_q.enable),
    .periodic_i(cfg_q.periodic), .narrow_i(cfg_q.narrow), .wr_touch_i(wr_touch),
    .cnt_i(cnt_val), .cmp_i(cmp_q), .per_i(per_q), .adv_o(adv), .adv_val_o(adv_val),
    .match_o(match_o), .wrap_o(wrap_o)
  );

  assign cmp_o    = cmp_q;
  assign period_o = per_q;
  assign cfg_o    = cfg_q;

endmodule

// File: tb/evt_cmp_channel_test.sv
module evt_cmp_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_run = 1'b0;
  logic [63:0] cnt_val = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic        match_o, wrap_o;
  logic [63:0] cmp_o, period_o;
  logic [3:0]  cfg_o;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  evt_cmp_channel uut (
    .clk(clk), .rst_n(rst_n), .cnt_run(cnt_run), .cnt_val(cnt_val),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .match_o(match_o),
    .wrap_o(wrap_o), .cmp_o(cmp_o), .period_o(period_o), .cfg_o(cfg_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cnt_run = 1'b0; wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic step(input logic [63:0] v, input logic run);
    @(negedge clk);
    cnt_val = v; cnt_run = run;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    int pulses, cycles, wraps;
    logic [31:0] lo, d;
    logic [63:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 cmp", cmp_o, '1);
    chk("R1 period", period_o, 0);
    chk("R1 cfg", {60'd0, cfg_o}, 0);
    chk("R1 match", {63'd0, match_o}, 0);
    chk("R1 wrap", {63'd0, wrap_o}, 0);

    // R7 all-ones comparator never matches
    wr(2'd0, 32'h1);
    for (int i = 0; i < 4; i++) begin
      step(i, 1'b1);
      chk("R7 all-ones no match", {63'd0, match_o}, 0);
    end

    // R4 one-shot write goes to comparator; R7 single match
    wr(2'd1, 32'd20);
    wr(2'd2, 32'd0);
    chk("R4 oneshot to cmp", cmp_o, 64'd20);
    chk("R4 period untouched", period_o, 0);
    pulses = 0;
    for (int i = 0; i <= 30; i++) begin
      step(i, 1'b1);
      chk("R7 oneshot sweep", {63'd0, match_o}, {63'd0, (i == 20)});
      pulses += match_o;
    end
    chk("R7 oneshot pulses", pulses, 1);

    // R7 comparator already behind fires at once
    wr(2'd1, 32'd3);
    step(31, 1'b1);
    chk("R7 behind fires", {63'd0, match_o}, 1);
    step(32, 1'b1);
    chk("R7 behind once", {63'd0, match_o}, 0);

    // R4/R5 periodic without set-value loads period, msb cleared
    wr(2'd0, 32'h3);
    wr(2'd2, 32'hFFFF_FFFF);
    chk("R5 period hi clip", period_o, 64'h7FFF_FFFF_0000_0000);
    chk("R4 cmp untouched", cmp_o, 64'd3);
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd10);
    chk("R4 setval to cmp", cmp_o, 64'd10);
    chk("R6 setval cleared", {60'd0, cfg_o}, 64'h3);
    wr(2'd1, 32'd5);
    wr(2'd2, 32'd0);
    chk("R4 period loaded", period_o, 64'd5);
    chk("R4 cmp kept", cmp_o, 64'd10);

    // R8 periodic sweep
    pulses = 0;
    for (int i = 0; i <= 40; i++) begin
      step(i, 1'b1);
      chk("R8 periodic sweep", {63'd0, match_o},
          {63'd0, (i >= 10 && ((i - 10) % 5) == 0)});
      pulses += match_o;
    end
    chk("R8 periodic pulses", pulses, 7);
    chk("R8 periodic cmp", cmp_o, 64'd45);

    // R8 catch-up: one addition per clock, one strobe
    pulses = 0; cycles = 0;
    for (int k = 0; k < 40; k++) begin
      step(100, 1'b1);
      pulses += match_o;
      cycles++;
      if (cmp_o > 64'd100) break;
    end
    chk("R8 catchup cycles", cycles, (100 - 45) / 5 + 1);
    chk("R8 catchup pulses", pulses, 1);
    chk("R8 catchup cmp", cmp_o, 64'd105);
    for (int i = 101; i <= 105; i++) begin
      step(i, 1'b1);
      chk("R8 after catchup", {63'd0, match_o}, {63'd0, (i == 105)});
    end

    // R2 narrow config truncates stored values
    wr(2'd0, 32'hB);
    wr(2'd2, 32'hABCD);
    wr(2'd1, 32'd7);
    wr(2'd2, 32'h55);
    chk("R2 pre cmp", cmp_o, {32'hABCD, 32'd110});
    chk("R2 pre period", period_o, {32'h55, 32'd7});
    wr(2'd0, 32'h7);
    chk("R2 trunc cmp", cmp_o, 64'd110);
    chk("R2 trunc period", period_o, 64'd7);
    chk("R2 cfg", {60'd0, cfg_o}, 64'h7);

    // R3/R5 narrow periodic with sum wrapping at 32 bits
    wr(2'd0, 32'hF);
    wr(2'd1, 32'hFFFF_FFFC);
    wr(2'd1, 32'h8000_0008);
    wr(2'd2, 32'h1234);
    chk("R3 hi write ignored cmp", cmp_o, 64'h0000_0000_FFFF_FFFC);
    chk("R5 narrow period clip", period_o, 64'd8);
    chk("R3 hi write ignored cfg", {60'd0, cfg_o}, 64'h7);
    wraps = 0;
    for (int i = 0; i <= 32; i++) begin
      v = 64'h1_FFFF_FFF0 + i;
      lo = v[31:0];
      d = lo - 32'hFFFF_FFFC;
      step(v, 1'b1);
      chk("R3 narrow periodic sweep", {63'd0, match_o},
          {63'd0, (!d[31] && d[2:0] == 3'd0)});
      wraps += wrap_o;
    end
    chk("R8 narrow wrapped cmp", cmp_o, 64'h14);
    chk("R9 no wrap when periodic", wraps, 0);

    // R9 rollover strobe before the match
    wr(2'd0, 32'h5);
    wr(2'd1, 32'd5);
    for (int i = 0; i <= 16; i++) begin
      v = 64'h3_FFFF_FFFA + i;
      step(v, 1'b1);
      chk("R9 wrap sweep", {63'd0, wrap_o}, {63'd0, (v[31:0] == 32'd0)});
      chk("R7 narrow oneshot", {63'd0, match_o}, {63'd0, (v[31:0] == 32'd5)});
    end
    // R9 no rollover strobe once matched
    wr(2'd1, 32'hFFFF_FFFD);
    for (int i = 0; i <= 10; i++) begin
      v = 64'h4_FFFF_FFFA + i;
      step(v, 1'b1);
      chk("R9 no wrap after match", {63'd0, wrap_o}, 0);
      chk("R7 match before wrap", {63'd0, match_o},
          {63'd0, (v[31:0] == 32'hFFFF_FFFD)});
    end

    // R10 halted counter: no strobe, then immediate match on run
    wr(2'd0, 32'h1);
    wr(2'd1, 32'd50);
    for (int i = 40; i <= 60; i++) begin
      step(i, 1'b0);
      chk("R10 halted no match", {63'd0, match_o}, 0);
    end
    chk("R10 cmp held", cmp_o, 64'd50);
    step(61, 1'b1);
    chk("R10 match on resume", {63'd0, match_o}, 1);

    // R10 channel disabled: no strobe, no advance
    wr(2'd0, 32'hB);
    wr(2'd1, 32'd70);
    wr(2'd1, 32'd4);
    wr(2'd0, 32'h2);
    for (int i = 80; i <= 85; i++) begin
      step(i, 1'b1);
      chk("R10 disabled no match", {63'd0, match_o}, 0);
    end
    chk("R10 disabled no advance", cmp_o, 64'd70);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule